// File: doc/BRIEF.md
# Two-Level Priority Arbiter with Weighted Round-Robin and Starvation Relief

This block decides which of six command sources gets the command path of a memory controller. The sources form two tiers: sources 0 to 3 make up the upper tier and sources 4 and 5 the lower tier. The lower tier is served only when the upper tier is idle. Inside a tier, the winner is the first requester in a rotating scan list. Each source has a weight: after it has won that many times, it moves to the back of its tier's list.

The strict tier priority can starve the lower tier. To prevent this, each source has a wait timer and a programmable threshold. When a requesting source's timer reaches its threshold, that source becomes *urgent*. An urgent source suppresses every tier above its own and is preferred over the non-urgent peers in its tier. This puts a bound on how long the source waits.

A mode input selects how the timers count. In wait-only mode a timer advances only while its source waits. In free-running mode it advances every cycle. The grant is computed combinationally from registered state, so it is valid in the same cycle as the request. The block's own state (timers, win counts, scan lists) updates on the next rising edge.

Top module: `arb_prio_relax`

## Requirements
- R1: While `rst` is high, `gnt` is all zero and `gnt_vld` is low. After reset, every timer and win count is zero and each tier's scan list is in ascending port order.
- R2: If no source is urgent, a lower-tier source (4 or 5) is never granted while any upper-tier source (0 to 3) is requesting.
- R3: Within the selected tier, the grant goes to the first eligible source in that tier's current scan list.
- R4: Each win increments the winner's win count. When the new count reaches the winner's weight, the count returns to zero and the winner moves to the back of its tier's scan list. A weight of 0 behaves as 1. `weight` packs port p in bits [4p+3:4p].
- R5: `gnt` is zero or one-hot and is set only for a requesting source.
- R6: A source whose threshold is 0 never becomes urgent. `relax_thr` packs port p in bits [8p+7:8p].
- R7: In wait-only mode (`free_run`=0), a timer increments, saturating at 255, on each cycle its source requests and is not granted. It clears on a cycle with a grant or with no request, and holds while the source is urgent. A source is urgent when it requests, its threshold is nonzero, and its timer is at or above the threshold.
- R8: In free-running mode (`free_run`=1), a timer increments every cycle, saturating at 255, and clears when its source is granted. Once it is at or above a nonzero threshold, it clears if the source is not requesting and holds if the source is requesting.
- R9: If any source is urgent, the selected tier is the highest tier that has an urgent source. Inside that tier, only urgent sources compete, and the scan list breaks ties.
- R10: `gnt_vld` is high exactly when some source requests and `rst` is low. The grant appears in the same cycle as the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 6 | Request line per source |
| weight | input | 24 | Weight per source, 4 bits each |
| relax_thr | input | 48 | Starvation threshold per source, 8 bits each |
| free_run | input | 1 | Timer mode: 1 free-running, 0 wait-only |
| gnt | output | 6 | One-hot grant |
| gnt_vld | output | 1 | A grant is issued this cycle |

## Verification
`gnt` and `gnt_vld` follow the current requests and the registered state with no delay. Timers, win counts and scan lists take the effect of a grant at the next rising edge, so a threshold crossing or a list rotation shows up in the grant one cycle after the edge that caused it. The bench changes inputs one nanosecond after a rising edge and compares against its reference model at the falling edge. The model advances its own state only on rising edges. The directed latency checks therefore count whole cycles from the first requesting cycle: a wait-only source with threshold 5 is expected to win on the sixth cycle of its request.

// File: rtl/arb_prio_relax_pkg.sv
package arb_prio_relax_pkg;
  typedef enum logic {
    MODE_WAIT = 1'b0,
    MODE_FREE = 1'b1
  } relax_mode_e;
endpackage

// File: rtl/relax_timer.sv
module relax_timer
  import arb_prio_relax_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  relax_mode_e   mode,
  input  logic          req,
  input  logic          gnt,
  input  logic [CW-1:0] thr,
  output logic          urgent
);
  logic [CW-1:0] tmr;
  logic [CW-1:0] tmr_inc;
  logic          hit;

  assign hit     = (thr != '0) && (tmr >= thr);
  assign urgent  = req && hit;
  assign tmr_inc = (&tmr) ? tmr : tmr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr <= '0;
    end else if (gnt) begin
      tmr <= '0;
    end else if (mode == MODE_FREE) begin
      if (hit) tmr <= req ? tmr : '0;
      else     tmr <= tmr_inc;
    end else begin
      if (!req)     tmr <= '0;
      else if (hit) tmr <= tmr;
      else          tmr <= tmr_inc;
    end
  end
endmodule

// File: rtl/wrr_group.sv
module wrr_group #(
  parameter int N  = 4,
  parameter int WW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  urg,
  input  logic [N*WW-1:0] weight,
  input  logic          take,
  output logic          any_req,
  output logic          any_urg,
  output logic [N-1:0]  sel
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ord [N];
  logic [WW-1:0] cnt [N];
  logic [N-1:0]  cand;
  logic          found;
  logic [IW-1:0] pos;
  logic [IW-1:0] win;
  logic [WW-1:0] wt_sel;
  logic          wrap;

  assign any_req = |req;
  assign any_urg = |urg;
  assign cand    = any_urg ? urg : req;

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int k = 0; k < N; k++) begin
      if (!found && cand[ord[k]]) begin
        found = 1'b1;
        pos   = IW'(k);
      end
    end
    win = ord[pos];
    for (int k = 0; k < N; k++) sel[k] = found && (win == IW'(k));
  end

  assign wt_sel = weight[int'(win)*WW +: WW];
  assign wrap   = ({1'b0, cnt[win]} + 1'b1) >=
                  ((wt_sel == '0) ? (WW+1)'(1) : {1'b0, wt_sel});

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N; k++) begin
        ord[k] <= IW'(k);
        cnt[k] <= '0;
      end
    end else if (take && found) begin
      if (wrap) begin
        cnt[win] <= '0;
        for (int k = 0; k < N - 1; k++)
          if (IW'(k) >= pos) ord[k] <= ord[k+1];
        ord[N-1] <= win;
      end else begin
        cnt[win] <= cnt[win] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_prio_relax.sv
module arb_prio_relax
  import arb_prio_relax_pkg::*;
#(
  parameter int NPORT = 6,
  parameter int NHI   = 4,
  parameter int CW    = 8,
  parameter int WW    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NPORT-1:0]   req,
  input  logic [NPORT*WW-1:0] weight,
  input  logic [NPORT*CW-1:0] relax_thr,
  input  logic               free_run,
  output logic [NPORT-1:0]   gnt,
  output logic               gnt_vld
);
  localparam int NLO = NPORT - NHI;

  relax_mode_e      mode;
  logic [NPORT-1:0] urg;
  logic             hi_any, hi_urg, lo_any, lo_urg;
  logic [NHI-1:0]   hi_sel;
  logic [NLO-1:0]   lo_sel;
  logic             pick_hi, pick_lo;

  assign mode = free_run ? MODE_FREE : MODE_WAIT;

  for (genvar i = 0; i < NPORT; i++) begin : g_tmr
    relax_timer #(.CW(CW)) u_tmr (
      .clk   (clk),
      .rst   (rst),
      .mode  (mode),
      .req   (req[i]),
      .gnt   (gnt[i]),
      .thr   (relax_thr[i*CW +: CW]),
      .urgent(urg[i])
    );
  end

  wrr_group #(.N(NHI), .WW(WW)) u_hi (
    .clk(clk), .rst(rst),
    .req(req[NHI-1:0]), .urg(urg[NHI-1:0]),
    .weight(weight[NHI*WW-1:0]),
    .take(pick_hi && !rst),
    .any_req(hi_any), .any_urg(hi_urg), .sel(hi_sel)
  );

  wrr_group #(.N(NLO), .WW(WW)) u_lo (
    .clk(clk), .rst(rst),
    .req(req[NPORT-1:NHI]), .urg(urg[NPORT-1:NHI]),
    .weight(weight[NPORT*WW-1:NHI*WW]),
    .take(pick_lo && !rst),
    .any_req(lo_any), .any_urg(lo_urg), .sel(lo_sel)
  );

  assign pick_hi = hi_urg || (hi_any && !lo_urg);
  assign pick_lo = !pick_hi && lo_any;

  assign gnt     = rst ? '0 : {(pick_lo ? lo_sel : '0), (pick_hi ? hi_sel : '0)};
  assign gnt_vld = |gnt;
endmodule

// File: rtl/arb_prio_relax_chk.sv
module arb_prio_relax_chk #(
  parameter int NPORT = 6,
  parameter int NHI   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [NPORT-1:0] req,
  input logic [NPORT-1:0] gnt,
  input logic             gnt_vld,
  input logic             lo_urg
);
  // R5
  onehot_gnt_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt));
  // R5
  gnt_has_req_chk: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0);
  // R10
  vld_match_chk: assert property (@(posedge clk) disable iff (rst) gnt_vld == (|req));
  // R2
  tier_order_chk: assert property (@(posedge clk) disable iff (rst)
    (|gnt[NPORT-1:NHI]) |-> (!(|req[NHI-1:0]) || lo_urg));
  // R1
  always @(posedge clk) if (rst) rst_quiet_chk: assert (gnt == '0 && !gnt_vld);
endmodule

bind arb_prio_relax arb_prio_relax_chk #(.NPORT(NPORT), .NHI(NHI)) u_chk (
  .clk(clk), .rst(rst), .req(req), .gnt(gnt), .gnt_vld(gnt_vld), .lo_urg(lo_urg)
);

// File: tb/tb_arb_prio_relax.sv
module tb_arb_prio_relax;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  req = '0;
  logic [23:0] weight = '0;
  logic [47:0] relax_thr = '0;
  logic        free_run = 1'b0;
  logic [5:0]  gnt;
  logic        gnt_vld;

  int total = 0, fails = 0;
  bit finished = 0;
  string ph = "R1";

  int tmr [6];
  int cnt [6];
  int q0 [$];
  int q1 [$];

  always #4 clk = ~clk;

  arb_prio_relax dut (
    .clk(clk), .rst(rst), .req(req), .weight(weight),
    .relax_thr(relax_thr), .free_run(free_run),
    .gnt(gnt), .gnt_vld(gnt_vld)
  );

  function automatic int thr_of(int p);
    return int'(relax_thr[p*8 +: 8]);
  endfunction

  function automatic int wt_of(int p);
    return int'(weight[p*4 +: 4]);
  endfunction

  function automatic bit is_urg(int p);
    return req[p] && thr_of(p) != 0 && tmr[p] >= thr_of(p);
  endfunction

  function automatic int pick();
    bit u0 = 0, u1 = 0, r0 = 0, r1 = 0, use_u;
    int g, p;
    for (int i = 0; i < 4; i++) begin u0 |= is_urg(i); r0 |= req[i]; end
    for (int i = 4; i < 6; i++) begin u1 |= is_urg(i); r1 |= req[i]; end
    if (u0) g = 0; else if (u1) g = 1; else if (r0) g = 0; else if (r1) g = 1;
    else return -1;
    use_u = (g == 0) ? u0 : u1;
    for (int k = 0; k < ((g == 0) ? q0.size() : q1.size()); k++) begin
      p = (g == 0) ? q0[k] : q1[k];
      if (use_u ? is_urg(p) : req[p]) return p;
    end
    return -1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 6; i++) begin tmr[i] = 0; cnt[i] = 0; end
      q0 = '{0, 1, 2, 3};
      q1 = '{4, 5};
    end else begin
      int w, lim;
      bit hit [6];
      w = pick();
      for (int i = 0; i < 6; i++) hit[i] = thr_of(i) != 0 && tmr[i] >= thr_of(i);
      for (int i = 0; i < 6; i++) begin
        if (i == w) tmr[i] = 0;
        else if (free_run) begin
          if (hit[i]) tmr[i] = req[i] ? tmr[i] : 0;
          else if (tmr[i] < 255) tmr[i]++;
        end else begin
          if (!req[i]) tmr[i] = 0;
          else if (!hit[i] && tmr[i] < 255) tmr[i]++;
        end
      end
      if (w >= 0) begin
        lim = (wt_of(w) == 0) ? 1 : wt_of(w);
        if (cnt[w] + 1 >= lim) begin
          cnt[w] = 0;
          if (w < 4) begin
            for (int k = 0; k < q0.size(); k++) if (q0[k] == w) begin q0.delete(k); break; end
            q0.push_back(w);
          end else begin
            for (int k = 0; k < q1.size(); k++) if (q1[k] == w) begin q1.delete(k); break; end
            q1.push_back(w);
          end
        end else cnt[w]++;
      end
    end
  end

  task automatic chk(string tag, bit ok, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      int w;
      logic [5:0] e;
      w = rst ? -1 : pick();
      e = (w >= 0) ? 6'(1 << w) : 6'd0;
      chk(ph, gnt == e && gnt_vld == (e != 0), {gnt_vld, gnt}, {(e != 0), e});
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic set_thr(int p, int v); relax_thr[p*8 +: 8] = 8'(v); endtask
  task automatic set_wt(int p, int v);  weight[p*4 +: 4] = 4'(v); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    int k;
    for (int p = 0; p < 6; p++) set_wt(p, 1);
    req = 6'h3f;
    tick(3);
    @(negedge clk); #1;
    chk("R1 reset quiet", gnt == 0 && !gnt_vld, gnt, 0);
    @(posedge clk); #1;
    rst = 1'b0; ph = "R3 scan order";
    req = 6'b000110; tick(3);
    req = 6'b001111; tick(8);
    req = 6'b001010; tick(4);
    req = 6'b110000; tick(4);
    ph = "R4 weights";
    set_wt(0, 3); set_wt(1, 2); set_wt(2, 1); set_wt(3, 0); set_wt(4, 2);
    req = 6'b001111; tick(16);
    req = 6'b110000; tick(6);
    ph = "R2 tier priority";
    req = 6'h3f; tick(12);
    ph = "R7 wait-only relief";
    req = 6'b001111; tick(1);
    set_thr(4, 5); req = 6'b011111;
    k = -1;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (k < 0 && gnt[4]) k = c;
      @(posedge clk); #1;
    end
    chk("R7 latency of port 4", k == 5, k, 5);
    ph = "R8 free-running relief";
    free_run = 1'b1; set_thr(4, 0); set_thr(5, 4);
    req = 6'b001111; tick(9);
    req = 6'b101111;
    k = -1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (k < 0 && gnt[5]) k = c;
      @(posedge clk); #1;
    end
    chk("R8 port 5 served within threshold", k >= 0 && k <= 4, k, 4);
    ph = "R9 several urgent";
    free_run = 1'b0;
    req = 6'b000000; tick(1);
    set_thr(1, 2); set_thr(4, 3); set_thr(5, 3);
    req = 6'h3f; tick(30);
    ph = "R6 zero threshold";
    for (int p = 0; p < 6; p++) set_thr(p, 0);
    req = 6'h3f; tick(20);
    free_run = 1'b1; tick(20);
    ph = "R5/R10 random";
    for (int c = 0; c < 400; c++) begin
      req = 6'($urandom);
      if (c % 25 == 0) begin
        for (int p = 0; p < 6; p++) begin
          set_wt(p, $urandom_range(0, 3));
          set_thr(p, $urandom_range(0, 7));
        end
        free_run = 1'($urandom);
      end
      tick(1);
    end
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule